// File: doc/BRIEF.md
# Vector Byte and Element Permute Engine

This block rearranges the bytes and elements of a 128-bit vector datapath. Each accepted operation takes two source vectors (A and B), an index vector, the current contents of the destination (used only by one lookup variant), a byte offset and an element size. It produces one permuted 128-bit result. The result is registered, so it appears exactly one clock after the request.

The operation set has six families. A byte window slides across the source pair. Elements are mirrored inside fixed-size containers. Bytes are gathered from a 32-byte table formed by the two sources. Element pairs are transposed as 2x2 tiles. Elements of the two sources are interleaved or de-interleaved, with a lower-half or upper-half variant. A request that pairs an opcode with an element size the opcode cannot use does not guess. It returns an all-zero result and raises an error pulse.

Top module: `lane_permute_unit`

## Requirements
- R1: `outValid` rises exactly one clock after a cycle with `inValid` high and is low one clock after a cycle with `inValid` low. `result` changes only one clock after an accepted request and otherwise holds its value.
- R2: Opcode 0 (window): result byte i equals byte i+`extOffset` of the 32-byte pair whose bytes 0..15 are `srcA` and bytes 16..31 are `srcB`. `elemSize` is ignored.
- R3: Opcodes 1, 2 and 3 mirror the order of the elements inside every 2-byte, 4-byte and 8-byte container of `srcA`, respectively. The element size must be smaller than the container.
- R4: Opcode 4 (gather, zeroing): result byte i is table byte k, where k is byte i of `indexVec`. Table bytes 0..15 are `srcA` and bytes 16..31 are `srcB`. Any k of 32 or more gives 0x00. `elemSize` is ignored.
- R5: Opcode 5 (gather, keeping): same as R4, except that an index of 32 or more gives byte i of `oldDst`.
- R6: Opcodes 6 and 7 (transpose, s=0 or 1): result element 2j is A[2j+s] and result element 2j+1 is B[2j+s].
- R7: Opcodes 8 and 9 (interleave, s=0 or 1, n elements per vector): result element 2j is A[j+s*n/2] and result element 2j+1 is B[j+s*n/2].
- R8: Opcodes 10 and 11 (de-interleave, s=0 or 1): result element j is element 2j+s of the 2n-element sequence made of A's elements followed by B's elements.
- R9: These requests give an all-zero result and `errFlag` high for that one output cycle:
  - opcodes 12..15;
  - `elemSize`=3 with any of opcodes 1..3 or 6..11;
  - opcode 1 with `elemSize` not 0;
  - opcode 2 with `elemSize`=2.

  `errFlag` is high only together with `outValid`.
- R10: Reset (`rstN` low) clears `outValid`, `errFlag` and `result` to zero.

Element size encoding: `elemSize` 0, 1 and 2 select 8-, 16- and 32-bit elements. Element 0 sits in the least significant bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe; the operand and control inputs are sampled when high |
| opcode | input | 4 | Operation select (see R2..R9) |
| elemSize | input | 2 | Element size: 0=8, 1=16, 2=32 bits, 3=illegal |
| extOffset | input | 4 | Byte offset for the window operation |
| srcA | input | 128 | First source vector |
| srcB | input | 128 | Second source vector |
| indexVec | input | 128 | Byte indices for the gather operations |
| oldDst | input | 128 | Prior destination value for the keeping gather |
| outValid | output | 1 | Result valid, one clock after the request |
| result | output | 128 | Permuted vector |
| errFlag | output | 1 | Illegal opcode/size combination for this result |

## Verification
A wrong decode strobe, for example a lost upper-half select or a swapped container size, shows up as misplaced bytes in `result` on the very next clock after the request. This makes it visible in the cycle the bench compares. A stuck or leaked valid or error register shows on `outValid` or `errFlag` within one clock, including during idle cycles. A result register that fails to hold shows up as a change in `result` between requests. The reference model therefore compares all three outputs on every clock, idle or busy, against element-level arithmetic computed from the requirements.

// File: rtl/perm_pkg.sv
package perm_pkg;
  localparam int BYTE_W = 8;

  localparam logic [3:0] OP_WINDOW   = 4'd0;
  localparam logic [3:0] OP_MIRROR2  = 4'd1;
  localparam logic [3:0] OP_MIRROR4  = 4'd2;
  localparam logic [3:0] OP_MIRROR8  = 4'd3;
  localparam logic [3:0] OP_GATHER_Z = 4'd4;
  localparam logic [3:0] OP_GATHER_K = 4'd5;
  localparam logic [3:0] OP_TILE_LO  = 4'd6;
  localparam logic [3:0] OP_TILE_HI  = 4'd7;
  localparam logic [3:0] OP_WEAVE_LO = 4'd8;
  localparam logic [3:0] OP_WEAVE_HI = 4'd9;
  localparam logic [3:0] OP_SPLIT_LO = 4'd10;
  localparam logic [3:0] OP_SPLIT_HI = 4'd11;

  typedef enum logic [2:0] {
    PK_WINDOW, PK_MIRROR, PK_GATHER, PK_TILE, PK_WEAVE, PK_SPLIT
  } permKind_e;

  typedef struct packed {
    logic      load;
    logic      illegal;
    permKind_e kind;
    logic      upper;
    logic [1:0] sizeLog;
    logic [1:0] contLog;
    logic      keepOld;
  } permStrobe_t;
endpackage

// File: rtl/perm_ctrl.sv
module perm_ctrl
  import perm_pkg::*;
(
  input  logic        inValid,
  input  logic [3:0]  opcode,
  input  logic [1:0]  elemSize,
  output permStrobe_t strobe
);
  always_comb begin
    strobe         = '0;
    strobe.load    = inValid;
    strobe.sizeLog = elemSize;
    strobe.kind    = PK_WINDOW;
    case (opcode)
      OP_WINDOW: strobe.kind = PK_WINDOW;
      OP_MIRROR2: begin
        strobe.kind    = PK_MIRROR;
        strobe.contLog = 2'd1;
        strobe.illegal = (elemSize != 2'd0);
      end
      OP_MIRROR4: begin
        strobe.kind    = PK_MIRROR;
        strobe.contLog = 2'd2;
        strobe.illegal = (elemSize > 2'd1);
      end
      OP_MIRROR8: begin
        strobe.kind    = PK_MIRROR;
        strobe.contLog = 2'd3;
        strobe.illegal = (elemSize == 2'd3);
      end
      OP_GATHER_Z: strobe.kind = PK_GATHER;
      OP_GATHER_K: begin
        strobe.kind    = PK_GATHER;
        strobe.keepOld = 1'b1;
      end
      OP_TILE_LO, OP_TILE_HI: begin
        strobe.kind    = PK_TILE;
        strobe.upper   = opcode[0];
        strobe.illegal = (elemSize == 2'd3);
      end
      OP_WEAVE_LO, OP_WEAVE_HI: begin
        strobe.kind    = PK_WEAVE;
        strobe.upper   = opcode[0];
        strobe.illegal = (elemSize == 2'd3);
      end
      OP_SPLIT_LO, OP_SPLIT_HI: begin
        strobe.kind    = PK_SPLIT;
        strobe.upper   = opcode[0];
        strobe.illegal = (elemSize == 2'd3);
      end
      default: strobe.illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/perm_datapath.sv
module perm_datapath
  import perm_pkg::*;
#(
  parameter int LANE_BYTES = 16,
  localparam int LANE_BITS = LANE_BYTES * BYTE_W,
  localparam int OFF_W     = $clog2(LANE_BYTES),
  localparam int TABLE_BYTES = 2 * LANE_BYTES,
  localparam int POOL_BYTES  = 3 * LANE_BYTES
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  permStrobe_t          strobe,
  input  logic [OFF_W-1:0]     extOffset,
  input  logic [LANE_BITS-1:0] srcA,
  input  logic [LANE_BITS-1:0] srcB,
  input  logic [LANE_BITS-1:0] indexVec,
  input  logic [LANE_BITS-1:0] oldDst,
  output logic                 outValid,
  output logic [LANE_BITS-1:0] result,
  output logic                 errFlag
);
  logic [POOL_BYTES*BYTE_W-1:0] pool;
  logic [BYTE_W-1:0]            laneOut [LANE_BYTES];
  logic [LANE_BITS-1:0]         nextVec;

  assign pool = {oldDst, srcB, srcA};

  for (genvar gB = 0; gB < LANE_BYTES; gB++) begin : g_lane
    int   sz, eIdx, off, src, idx, halfN;
    logic zeroB;
    always_comb begin
      sz    = int'(strobe.sizeLog);
      eIdx  = gB >> sz;
      off   = gB & ((1 << sz) - 1);
      halfN = (LANE_BYTES >> sz) / 2;
      idx   = int'(indexVec[BYTE_W*gB +: BYTE_W]);
      zeroB = 1'b0;
      src   = gB;
      case (strobe.kind)
        PK_WINDOW: src = gB + int'(extOffset);
        PK_MIRROR: src = ((eIdx ^ ((1 << (int'(strobe.contLog) - sz)) - 1)) << sz) | off;
        PK_GATHER: begin
          if (idx < TABLE_BYTES)  src = idx;
          else if (strobe.keepOld) src = TABLE_BYTES + gB;
          else zeroB = 1'b1;
        end
        PK_TILE:  src = ((((eIdx & ~1) | int'(strobe.upper)) << sz) | off)
                        + ((eIdx & 1) * LANE_BYTES);
        PK_WEAVE: src = ((((eIdx >> 1) + int'(strobe.upper) * halfN) << sz) | off)
                        + ((eIdx & 1) * LANE_BYTES);
        PK_SPLIT: src = (((2 * eIdx) + int'(strobe.upper)) << sz) | off;
        default:  zeroB = 1'b1;
      endcase
      if (src < 0 || src >= POOL_BYTES) zeroB = 1'b1;
      laneOut[gB] = zeroB ? '0 : pool[BYTE_W*src +: BYTE_W];
    end
  end

  always_comb begin
    for (int i = 0; i < LANE_BYTES; i++) nextVec[BYTE_W*i +: BYTE_W] = laneOut[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      errFlag  <= 1'b0;
      result   <= '0;
    end else begin
      outValid <= strobe.load;
      errFlag  <= strobe.load & strobe.illegal;
      if (strobe.load) result <= strobe.illegal ? '0 : nextVec;
    end
  end
endmodule

// File: rtl/lane_permute_unit.sv
module lane_permute_unit
  import perm_pkg::*;
#(
  parameter int LANE_BYTES = 16,
  localparam int LANE_BITS = LANE_BYTES * BYTE_W,
  localparam int OFF_W     = $clog2(LANE_BYTES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [3:0]           opcode,
  input  logic [1:0]           elemSize,
  input  logic [OFF_W-1:0]     extOffset,
  input  logic [LANE_BITS-1:0] srcA,
  input  logic [LANE_BITS-1:0] srcB,
  input  logic [LANE_BITS-1:0] indexVec,
  input  logic [LANE_BITS-1:0] oldDst,
  output logic                 outValid,
  output logic [LANE_BITS-1:0] result,
  output logic                 errFlag
);
  permStrobe_t strobe;

  perm_ctrl u_ctrl (
    .inValid (inValid),
    .opcode  (opcode),
    .elemSize(elemSize),
    .strobe  (strobe)
  );

  perm_datapath #(.LANE_BYTES(LANE_BYTES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .extOffset(extOffset),
    .srcA     (srcA),
    .srcB     (srcB),
    .indexVec (indexVec),
    .oldDst   (oldDst),
    .outValid (outValid),
    .result   (result),
    .errFlag  (errFlag)
  );
endmodule

// File: rtl/perm_checker.sv
module perm_checker #(
  parameter int LANE_BYTES = 16,
  localparam int LANE_BITS = LANE_BYTES * 8,
  localparam int OFF_W     = $clog2(LANE_BYTES)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 inValid,
  input logic [3:0]           opcode,
  input logic [1:0]           elemSize,
  input logic [OFF_W-1:0]     extOffset,
  input logic [LANE_BITS-1:0] srcA,
  input logic [LANE_BITS-1:0] indexVec,
  input logic                 outValid,
  input logic [LANE_BITS-1:0] result,
  input logic                 errFlag
);
  logic allOutOfRange;
  always_comb begin
    allOutOfRange = 1'b1;
    for (int i = 0; i < LANE_BYTES; i++)
      if (int'(indexVec[8*i +: 8]) < 2 * LANE_BYTES) allOutOfRange = 1'b0;
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);                                            // R1
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);                                          // R1
  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(result));                                    // R1
  AST_WINDOW_ZERO_OFFSET: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opcode == 4'd0 && extOffset == '0) |=> (result == $past(srcA))); // R2
  AST_GATHER_ALL_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opcode == 4'd4 && allOutOfRange) |=> (result == '0)); // R4
  AST_BAD_OPCODE_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opcode >= 4'd12) |=> errFlag);                        // R9
  AST_BAD_SIZE_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && elemSize == 2'd3 && opcode != 4'd0 && opcode != 4'd4 && opcode != 4'd5)
      |=> errFlag);                                                   // R9
  AST_ERR_WITH_VALID: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> outValid);                                            // R9
  AST_ERR_ZERO_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> (result == '0));                                      // R9
endmodule

bind lane_permute_unit perm_checker #(.LANE_BYTES(LANE_BYTES)) u_checker (
  .clk(clk), .rstN(rstN), .inValid(inValid), .opcode(opcode), .elemSize(elemSize),
  .extOffset(extOffset), .srcA(srcA), .indexVec(indexVec), .outValid(outValid),
  .result(result), .errFlag(errFlag)
);

// File: tb/lane_permute_unit_bench.sv
`timescale 1ns/1ps
module lane_permute_unit_bench;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [3:0]   opcode = '0;
  logic [1:0]   elemSize = '0;
  logic [3:0]   extOffset = '0;
  logic [127:0] srcA = '0, srcB = '0, indexVec = '0, oldDst = '0;
  logic         outValid, errFlag;
  logic [127:0] result;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  lane_permute_unit u_lane_permute_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opcode(opcode), .elemSize(elemSize),
    .extOffset(extOffset), .srcA(srcA), .srcB(srcB), .indexVec(indexVec),
    .oldDst(oldDst), .outValid(outValid), .result(result), .errFlag(errFlag)
  );

  function automatic logic [31:0] getE(logic [127:0] v, int sz, int i);
    int w = 8 << sz;
    logic [127:0] m = (w == 128) ? '1 : ((128'(1) << w) - 128'(1));
    return 32'((v >> (i * w)) & m);
  endfunction

  function automatic logic [127:0] putE(logic [127:0] v, int sz, int i, logic [31:0] x);
    int w = 8 << sz;
    logic [127:0] m = (128'(1) << w) - 128'(1);
    return v | ((128'(x) & m) << (i * w));
  endfunction

  function automatic bit isLegal(int op, int sz);
    if (op > 11) return 0;
    if (op == 0 || op == 4 || op == 5) return 1;
    if (sz == 3) return 0;
    if (op == 1) return sz == 0;
    if (op == 2) return sz <= 1;
    return 1;
  endfunction

  function automatic logic [127:0] refCalc(int op, int sz, logic [127:0] a, logic [127:0] b,
                                           logic [127:0] c, logic [127:0] od, int off);
    logic [127:0] r = '0;
    logic [255:0] pair = {b, a};
    int n = 16 >> sz;
    if (!isLegal(op, sz)) return '0;
    case (op)
      0: r = 128'(pair >> (off * 8));
      1, 2, 3: begin
        int k = (2 << (op - 1)) >> sz;
        for (int e = 0; e < n; e++)
          r = putE(r, sz, e, getE(a, sz, (e / k) * k + (k - 1 - e % k)));
      end
      4, 5: for (int i = 0; i < 16; i++) begin
        int ix = int'(c[8*i +: 8]);
        logic [7:0] v;
        if (ix < 32) v = pair[8*ix +: 8];
        else if (op == 5) v = od[8*i +: 8];
        else v = 8'h00;
        r[8*i +: 8] = v;
      end
      6, 7: for (int j = 0; j < n / 2; j++) begin
        r = putE(r, sz, 2*j,   getE(a, sz, 2*j + op - 6));
        r = putE(r, sz, 2*j+1, getE(b, sz, 2*j + op - 6));
      end
      8, 9: for (int j = 0; j < n / 2; j++) begin
        r = putE(r, sz, 2*j,   getE(a, sz, j + (op - 8) * n / 2));
        r = putE(r, sz, 2*j+1, getE(b, sz, j + (op - 8) * n / 2));
      end
      default: for (int j = 0; j < n; j++) begin
        int s = 2*j + op - 10;
        r = putE(r, sz, j, (s < n) ? getE(a, sz, s) : getE(b, sz, s - n));
      end
    endcase
    return r;
  endfunction

  function automatic string tagOf(int op, int sz);
    if (!isLegal(op, sz)) return "R9";
    case (op)
      0: return "R2";
      1, 2, 3: return "R3";
      4: return "R4";
      5: return "R5";
      6, 7: return "R6";
      8, 9: return "R7";
      default: return "R8";
    endcase
  endfunction

  // Reference model, advanced on every clock edge
  logic         expValid = 1'b0, expErr = 1'b0;
  logic [127:0] expResult = '0;
  string        expTag = "R10";
  always @(posedge clk) begin
    if (!rstN) begin
      expValid <= 1'b0; expErr <= 1'b0; expResult <= '0; expTag <= "R10";
    end else begin
      expValid <= inValid;
      expErr   <= inValid && !isLegal(int'(opcode), int'(elemSize));
      if (inValid) begin
        expResult <= refCalc(int'(opcode), int'(elemSize), srcA, srcB, indexVec, oldDst,
                             int'(extOffset));
        expTag <= tagOf(int'(opcode), int'(elemSize));
      end else expTag <= "R1";
    end
  end

  bit compareOn = 0;
  always @(negedge clk) begin
    if (compareOn) begin
      checks++;
      if (outValid !== expValid || errFlag !== expErr || result !== expResult) begin
        fails++;
        $display("FAIL %s: valid=%0b err=%0b result=%032h expected valid=%0b err=%0b result=%032h",
                 expTag, outValid, errFlag, result, expValid, expErr, expResult);
      end
    end
  end

  task automatic issue(int op, int sz, logic [127:0] a, logic [127:0] b,
                       logic [127:0] c, logic [127:0] od, int off);
    @(negedge clk);
    inValid = 1'b1; opcode = 4'(op); elemSize = 2'(sz); extOffset = 4'(off);
    srcA = a; srcB = b; indexVec = c; oldDst = od;
  endtask

  task automatic idle(int cyc);
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      srcA = ~srcA;
      opcode = 4'd15;
    end
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic runAll();
    logic [127:0] pa, pb, pc, po;
    for (int i = 0; i < 16; i++) begin
      pa[8*i +: 8] = 8'(i);
      pb[8*i +: 8] = 8'(16 + i);
      po[8*i +: 8] = 8'(8'hE0 + i);
    end
    pc = {8'd255, 8'd33, 8'd32, 8'd31, 8'd16, 8'd15, 8'd0, 8'd64,
          8'd1, 8'd17, 8'd30, 8'd2, 8'd128, 8'd5, 8'd20, 8'd9};
    // R2 window offsets incl. boundaries, size ignored
    issue(0, 0, pa, pb, pc, po, 0);
    issue(0, 3, pa, pb, pc, po, 5);
    issue(0, 1, pa, pb, pc, po, 15);
    idle(2);
    // R3 mirror in each container and size
    issue(1, 0, pa, pb, pc, po, 0);
    for (int s = 0; s < 2; s++) issue(2, s, pa, pb, pc, po, 0);
    for (int s = 0; s < 3; s++) issue(3, s, pa, pb, pc, po, 0);
    // R4/R5 gathers with in-range and out-of-range indices
    issue(4, 2, pa, pb, pc, po, 0);
    issue(5, 3, pa, pb, pc, po, 0);
    issue(4, 0, pa, pb, {16{8'd32}}, po, 0);
    issue(5, 0, pa, pb, {16{8'd200}}, po, 0);
    idle(1);
    // R6/R7/R8 both variants, all sizes
    for (int op = 6; op < 12; op++)
      for (int s = 0; s < 3; s++) issue(op, s, pa, pb, pc, po, 0);
    // R9 illegal combinations
    issue(12, 0, pa, pb, pc, po, 0);
    issue(15, 1, pa, pb, pc, po, 0);
    issue(1, 1, pa, pb, pc, po, 0);
    issue(2, 2, pa, pb, pc, po, 0);
    issue(8, 3, pa, pb, pc, po, 0);
    issue(6, 3, pa, pb, pc, po, 0);
    issue(3, 3, pa, pb, pc, po, 0);
    // R1 hold during idle after a legal result
    issue(9, 1, pa, pb, pc, po, 0);
    idle(4);
    // mixed random traffic
    for (int k = 0; k < 400; k++) begin
      if (($urandom % 5) == 0) idle(1);
      issue(int'($urandom % 16), int'($urandom % 4), rnd128(), rnd128(),
            (($urandom % 2) == 0) ? rnd128() : (rnd128() & {16{8'h3F}}), rnd128(),
            int'($urandom % 16));
    end
    idle(3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (outValid !== 1'b0 || errFlag !== 1'b0 || result !== '0) begin
      fails++;
      $display("FAIL R10: valid=%0b err=%0b result=%032h expected 0 0 0", outValid, errFlag, result);
    end
    rstN = 1'b1;
    compareOn = 1;
    fork
      runAll();
      begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    compareOn = 0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule